// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Controller

This controller links a request-side port to an external synchronous SRAM. The SRAM moves two words per address, one on each half of its clock period. A user issues reads and writes through separate valid/ready channels. Each write carries an address and a two-word payload. Each read returns one two-word result, marked by a single-cycle response-valid pulse, and results come back in the order the reads were accepted.

The block runs on a clock at twice the SRAM clock rate, so every cycle of `clk_i` is one SRAM half-cycle, or tick. The SRAM clock is produced as `sram_k_o`: it is high on even ticks, where commands may be launched, and low on odd ticks. Write beats leave two and three ticks after a write command. The SRAM returns read beats five and six ticks after a read command and flags them with a data-valid strobe. The controller captures read data only while that strobe is high. Writes and reads share one data bus, so the scheduler spaces commands to keep the bus from ever being driven from both ends. When both kinds of request wait at once, the scheduler alternates between them.

Top module: `sram_ddr_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `sram_cmd_o`, `sram_d_oe_o`, `rsp_valid_o`, `rd_ready_o` and `wr_ready_o` are all 0 when no request is pending.
- R2: `sram_cmd_o` is high only in ticks where `sram_k_o` is 1. Two commands are at least 4 ticks apart. Back-to-back commands of the same kind, with requests waiting, are exactly 4 ticks apart.
- R3: For a write command in tick t, `sram_d_oe_o` is 1 in ticks t+2 and t+3 only. `sram_d_o` carries `wr_data_i[DATA_W-1:0]` in t+2 and `wr_data_i[2*DATA_W-1:DATA_W]` in t+3.
- R4: The first word seen with `sram_qvld_i` high becomes `rsp_data_o[DATA_W-1:0]` and the second becomes the upper half. `rsp_valid_o` is high for one cycle, in the cycle after the second beat, which is tick t+7 for a read command in tick t.
- R5: Values on `sram_q_i` while `sram_qvld_i` is 0 have no effect on `rsp_data_o`.
- R6: A write command follows a read command by at least 8 ticks. A read may follow a write after 4 ticks. `sram_d_oe_o` is never 1 in a tick where `sram_qvld_i` is 1.
- R7: Exactly one response is produced per accepted read, in acceptance order.
- R8: When read and write requests are both valid, the command issued is of the kind opposite to the previous command. After reset, a read goes first. A lone request of either kind is served.
- R9: A request is accepted in a cycle where its valid and ready are both high. Its address appears on `sram_addr_o` in the tick where `sram_cmd_o` is 1, with `sram_rd_o` = 1 for a read and 0 for a write.
- R10: A read of an address returns the two words most recently written to it.
- R11: `DATA_W` must be 8, 9, 18 or 36. Any other value is flagged at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the SRAM clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | Read request valid |
| rd_ready_o | output | 1 | Read request accepted this cycle |
| rd_addr_i | input | ADDR_W | Read address |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write request accepted this cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 2*DATA_W | Write payload, lower word transferred first |
| rsp_valid_o | output | 1 | Read result valid pulse |
| rsp_data_o | output | 2*DATA_W | Read result, first beat in lower half |
| sram_k_o | output | 1 | SRAM clock, high on even ticks |
| sram_cmd_o | output | 1 | Command present this tick |
| sram_rd_o | output | 1 | Command kind: 1 read, 0 write |
| sram_addr_o | output | ADDR_W | Command address |
| sram_d_o | output | DATA_W | Write beat toward the SRAM |
| sram_d_oe_o | output | 1 | Drive enable for the shared data bus |
| sram_q_i | input | DATA_W | Read beat from the SRAM |
| sram_qvld_i | input | 1 | Read beat valid strobe |

## Verification
The hardest case to reach is a read and a write waiting in the same cycle right after a read. That is the only case where the turnaround gap, the alternation rule and the bus-sharing rule all matter together. The bench reaches it by forking a write stream and a read stream that start on the same edge and refill their valid at once after each acceptance. It then checks the command order and the 4-tick and 8-tick gaps from the recorded command log. The behavioural SRAM drives changing junk on the read bus whenever the strobe is low, so any capture that is not gated by the strobe corrupts the compared results.

// File: rtl/sram_ddr_pkg.sv
package sram_ddr_pkg;
  localparam int unsigned CMD_GAP_TICKS  = 4;  // two SRAM cycles between addresses
  localparam int unsigned TURN_GAP_TICKS = 8;  // read followed by write
  localparam int unsigned WR_BEAT_DLY    = 2;  // first write beat after command
  localparam int unsigned RD_BEAT_DLY    = 5;  // first read beat after command

  function automatic bit width_supported(input int unsigned w);
    return (w == 8) || (w == 9) || (w == 18) || (w == 36);
  endfunction
endpackage

// File: rtl/sram_ddr_sched.sv
module sram_ddr_sched
  import sram_ddr_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              rd_ready_o,
  output logic              wr_ready_o,
  output logic              sram_k_o,
  output logic              sram_cmd_o,
  output logic              sram_rd_o,
  output logic [ADDR_W-1:0] sram_addr_o
);
  localparam int unsigned CNT_W = $clog2(TURN_GAP_TICKS + 1);
  localparam logic [CNT_W-1:0] GAP_C  = CNT_W'(CMD_GAP_TICKS);
  localparam logic [CNT_W-1:0] TURN_C = CNT_W'(TURN_GAP_TICKS);

  logic             k_q, cmd_q, rd_q, last_rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic slot, pref_wr, rd_ok, wr_ok, gnt_rd, gnt_wr;

  always_comb begin
    slot    = !k_q;  // next tick is even
    pref_wr = (rd_valid_i && wr_valid_i) ? last_rd_q : wr_valid_i;
    rd_ok   = slot && (cnt_q >= GAP_C);
    wr_ok   = slot && (cnt_q >= (last_rd_q ? TURN_C : GAP_C));
    gnt_rd  = rd_valid_i && rd_ok && !pref_wr;
    gnt_wr  = wr_valid_i && wr_ok && pref_wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q       <= 1'b1;
      cmd_q     <= 1'b0;
      rd_q      <= 1'b0;
      last_rd_q <= 1'b0;
      cnt_q     <= TURN_C;
      addr_q    <= '0;
    end else begin
      k_q   <= !k_q;
      cmd_q <= gnt_rd || gnt_wr;
      rd_q  <= gnt_rd;
      if (gnt_rd)      addr_q <= rd_addr_i;
      else if (gnt_wr) addr_q <= wr_addr_i;
      if (gnt_rd || gnt_wr) begin
        cnt_q     <= CNT_W'(1);
        last_rd_q <= gnt_rd;
      end else if (cnt_q < TURN_C) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign rd_ready_o  = gnt_rd;
  assign wr_ready_o  = gnt_wr;
  assign sram_k_o    = k_q;
  assign sram_cmd_o  = cmd_q;
  assign sram_rd_o   = rd_q;
  assign sram_addr_o = addr_q;

  assert_even_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_cmd_o |-> sram_k_o);
  assert_cmd_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_cmd_o |-> (!$past(sram_cmd_o, 1) && !$past(sram_cmd_o, 2) && !$past(sram_cmd_o, 3)));
  assert_turnaround_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_cmd_o && !sram_rd_o) |-> !$past(sram_cmd_o && sram_rd_o, 4));
endmodule

// File: rtl/sram_ddr_wr_path.sv
module sram_ddr_wr_path
  import sram_ddr_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_i,
  input  logic [2*DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]   d_o,
  output logic                oe_o
);
  localparam int unsigned BEATS = 2;

  logic [BEATS-1:0][DATA_W-1:0] beat_q;
  logic [WR_BEAT_DLY:0]         sh_q;
  logic [DATA_W-1:0]            d_q;
  logic                         oe_q;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      beat_q[b] <= '0;
      else if (issue_i) beat_q[b] <= data_i[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      d_q  <= '0;
      oe_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[WR_BEAT_DLY-1:0], issue_i};
      oe_q <= sh_q[WR_BEAT_DLY-1] || sh_q[WR_BEAT_DLY];
      if (sh_q[WR_BEAT_DLY-1])    d_q <= beat_q[0];
      else if (sh_q[WR_BEAT_DLY]) d_q <= beat_q[1];
      else                        d_q <= '0;
    end
  end

  assign d_o  = d_q;
  assign oe_o = oe_q;

  assert_oe_two_ticks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |=> (oe_q ##1 !oe_q));
endmodule

// File: rtl/sram_ddr_rd_capture.sv
module sram_ddr_rd_capture #(
  parameter int unsigned DATA_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   q_i,
  input  logic                qvld_i,
  output logic                rsp_valid_o,
  output logic [2*DATA_W-1:0] rsp_data_o
);
  logic                half_q, rsp_valid_q;
  logic [DATA_W-1:0]   lo_q;
  logic [2*DATA_W-1:0] rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      lo_q        <= '0;
      rsp_q       <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (qvld_i) begin
        if (!half_q) begin
          lo_q   <= q_i;
          half_q <= 1'b1;
        end else begin
          rsp_q       <= {q_i, lo_q};
          rsp_valid_q <= 1'b1;
          half_q      <= 1'b0;
        end
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_q;

  assert_rsp_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_rsp_after_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(qvld_i, 1) && $past(qvld_i, 2)));
endmodule

// File: rtl/sram_ddr_ctrl.sv
module sram_ddr_ctrl
  import sram_ddr_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 22
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_valid_i,
  output logic                rd_ready_o,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic                wr_valid_i,
  output logic                wr_ready_o,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [2*DATA_W-1:0] wr_data_i,
  output logic                rsp_valid_o,
  output logic [2*DATA_W-1:0] rsp_data_o,
  output logic                sram_k_o,
  output logic                sram_cmd_o,
  output logic                sram_rd_o,
  output logic [ADDR_W-1:0]   sram_addr_o,
  output logic [DATA_W-1:0]   sram_d_o,
  output logic                sram_d_oe_o,
  input  logic [DATA_W-1:0]   sram_q_i,
  input  logic                sram_qvld_i
);
  initial begin : width_chk
    assert_width_R11: assert (width_supported(DATA_W))
      else $error("unsupported DATA_W %0d", DATA_W);
  end

  sram_ddr_sched #(.ADDR_W(ADDR_W)) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_valid_i  (rd_valid_i),
    .rd_addr_i   (rd_addr_i),
    .wr_valid_i  (wr_valid_i),
    .wr_addr_i   (wr_addr_i),
    .rd_ready_o  (rd_ready_o),
    .wr_ready_o  (wr_ready_o),
    .sram_k_o    (sram_k_o),
    .sram_cmd_o  (sram_cmd_o),
    .sram_rd_o   (sram_rd_o),
    .sram_addr_o (sram_addr_o)
  );

  sram_ddr_wr_path #(.DATA_W(DATA_W)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (wr_ready_o),
    .data_i  (wr_data_i),
    .d_o     (sram_d_o),
    .oe_o    (sram_d_oe_o)
  );

  sram_ddr_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .q_i         (sram_q_i),
    .qvld_i      (sram_qvld_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );

  assert_no_contention_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_qvld_i |-> !sram_d_oe_o);
  assert_wr_beat_lag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_d_oe_o) |-> $past(sram_cmd_o && !sram_rd_o, WR_BEAT_DLY));
  assert_rd_beat_lag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_qvld_i) |-> $past(sram_cmd_o && sram_rd_o, RD_BEAT_DLY));
endmodule

// File: tb/tb_sram_ddr_ctrl.sv
module tb_sram_ddr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 18;
  localparam int AW = 22;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_valid = 1'b0, wr_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [2*DW-1:0] wr_data = '0;
  logic rd_ready, wr_ready, rsp_valid;
  logic [2*DW-1:0] rsp_data;
  logic sram_k, sram_cmd, sram_rd, sram_d_oe;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_d;
  logic [DW-1:0] q_r = '0;
  logic qvld_r = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ddr_ctrl #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_addr_i(rd_addr),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .sram_k_o(sram_k), .sram_cmd_o(sram_cmd), .sram_rd_o(sram_rd), .sram_addr_o(sram_addr),
    .sram_d_o(sram_d), .sram_d_oe_o(sram_d_oe), .sram_q_i(q_r), .sram_qvld_i(qvld_r)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2*DW-1:0] init_val(input logic [AW-1:0] a);
    return {DW'(a) ^ DW'('h155), DW'(a) ^ DW'('h2a3)};
  endfunction

  // behavioural SRAM
  logic [2*DW-1:0] mem [logic [AW-1:0]];
  logic [2*DW-1:0] shadow [logic [AW-1:0]];
  logic [4:0] rdp = '0;
  logic [2:0] wrp = '0;
  logic [AW-1:0] rap [5];
  logic [AW-1:0] wap [3];
  logic [DW-1:0] wlo = '0;

  function automatic logic [2*DW-1:0] mem_rd(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : init_val(a);
  endfunction

  // monitor state
  int last_cmd_cyc = -1;
  bit last_was_rd = 0;
  int gap_q [$];
  bit kind_q [$];
  bit exp_kind_q [$];
  logic [AW-1:0] exp_addr_q [$];
  logic [2*DW-1:0] exp_data_q [$];
  int exp_cyc_q [$];
  int gap;

  always @(posedge clk) begin
    if (rst_ni) begin
      cyc = cyc + 1;
      // write beat capture
      if (wrp[1]) begin
        check(sram_d_oe, "R3", "oe first beat", 64'(sram_d_oe), 64'd1);
        wlo = sram_d;
      end else if (wrp[2]) begin
        check(sram_d_oe, "R3", "oe second beat", 64'(sram_d_oe), 64'd1);
        mem[wap[2]] = {sram_d, wlo};
      end else if (sram_d_oe) begin
        check(1'b0, "R3", "oe outside beats", 64'd1, 64'd0);
      end
      if (sram_d_oe)
        check(!qvld_r, "R6", "bus contention", 64'(qvld_r), 64'd0);
      // command monitor
      if (sram_cmd) begin
        check(sram_k, "R2", "command on odd tick", 64'(sram_k), 64'd1);
        gap = (last_cmd_cyc < 0) ? 99 : cyc - last_cmd_cyc;
        check(gap >= 4, "R2", "command gap", 64'(gap), 64'd4);
        if (!sram_rd && last_was_rd)
          check(gap >= 8, "R6", "write after read gap", 64'(gap), 64'd8);
        gap_q.push_back(gap);
        kind_q.push_back(sram_rd);
        if (exp_kind_q.size() > 0) begin
          check(exp_kind_q[0] == sram_rd, "R9", "command kind", 64'(sram_rd), 64'(exp_kind_q[0]));
          check(exp_addr_q[0] == sram_addr, "R9", "command addr", 64'(sram_addr), 64'(exp_addr_q[0]));
          void'(exp_kind_q.pop_front());
          void'(exp_addr_q.pop_front());
        end else begin
          check(1'b0, "R9", "unexpected command", 64'(sram_addr), 64'd0);
        end
        if (sram_rd) exp_cyc_q.push_back(cyc + 7);
        last_cmd_cyc = cyc;
        last_was_rd  = sram_rd;
      end
      // response monitor
      if (rsp_valid) begin
        if (exp_cyc_q.size() > 0 && exp_data_q.size() > 0) begin
          check(exp_cyc_q[0] == cyc, "R4", "response tick", 64'(cyc), 64'(exp_cyc_q[0]));
          check(exp_data_q[0] == rsp_data, "R10", "read data", 64'(rsp_data), 64'(exp_data_q[0]));
          void'(exp_cyc_q.pop_front());
          void'(exp_data_q.pop_front());
        end else begin
          check(1'b0, "R7", "extra response", 64'(rsp_data), 64'd0);
        end
      end else if (exp_cyc_q.size() > 0 && exp_cyc_q[0] == cyc) begin
        check(1'b0, "R7", "missing response", 64'd0, 64'(exp_cyc_q[0]));
        void'(exp_cyc_q.pop_front());
        if (exp_data_q.size() > 0) void'(exp_data_q.pop_front());
      end
    end
    // SRAM pipelines
    rdp <= {rdp[3:0], sram_cmd && sram_rd};
    wrp <= {wrp[1:0], sram_cmd && !sram_rd};
    rap[0] <= sram_addr;
    for (int i = 1; i < 5; i++) rap[i] <= rap[i-1];
    wap[0] <= sram_addr;
    for (int i = 1; i < 3; i++) wap[i] <= wap[i-1];
    qvld_r <= rdp[3] || rdp[4];
    if (rdp[3])      q_r <= mem_rd(rap[3])[DW-1:0];
    else if (rdp[4]) q_r <= mem_rd(rap[4])[2*DW-1:DW];
    else             q_r <= DW'(cyc * 37 + 11);  // junk while strobe low
  end

  task automatic do_rd(input logic [AW-1:0] a);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr  = a;
    while (1) begin
      #1;
      if (rd_ready) begin
        exp_kind_q.push_back(1'b1);
        exp_addr_q.push_back(a);
        exp_data_q.push_back(shadow.exists(a) ? shadow[a] : init_val(a));
        @(posedge clk);
        #1 rd_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [2*DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    while (1) begin
      #1;
      if (wr_ready) begin
        exp_kind_q.push_back(1'b0);
        exp_addr_q.push_back(a);
        shadow[a] = d;
        @(posedge clk);
        #1 wr_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
  endtask

  task automatic clear_log();
    gap_q.delete();
    kind_q.delete();
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!sram_cmd && !sram_d_oe && !rsp_valid, "R1", "outputs in reset",
          {61'd0, sram_cmd, sram_d_oe, rsp_valid}, 64'd0);
    check(!rd_ready && !wr_ready, "R1", "ready in reset", {62'd0, rd_ready, wr_ready}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!sram_cmd && !sram_d_oe && !rsp_valid, "R1", "outputs after release",
          {61'd0, sram_cmd, sram_d_oe, rsp_valid}, 64'd0);

    // R3 R10: single write then read
    do_wr(22'h00_0010, 36'h1_2345_6789);
    do_rd(22'h00_0010);
    drain();

    // R2 R4 R5 R7: back-to-back reads of unwritten locations
    clear_log();
    for (int i = 0; i < 4; i++) do_rd(AW'(22'h00_0200 + i));
    drain();
    check(kind_q.size() == 4, "R7", "read command count", 64'(kind_q.size()), 64'd4);
    for (int i = 1; i < 4 && i < gap_q.size(); i++)
      check(gap_q[i] == 4, "R2", "read-read spacing", 64'(gap_q[i]), 64'd4);

    // R6: read right after write at minimum spacing
    clear_log();
    do_wr(22'h00_0020, 36'h0_0ABC_DEF1);
    do_rd(22'h00_0020);
    drain();
    if (gap_q.size() == 2)
      check(gap_q[1] == 4, "R6", "write-read spacing", 64'(gap_q[1]), 64'd4);
    else
      check(1'b0, "R6", "write-read command count", 64'(gap_q.size()), 64'd2);

    // R8 R6: concurrent streams after a read
    clear_log();
    fork
      begin
        for (int i = 0; i < 3; i++) do_wr(AW'(22'h00_0100 + i), 36'(64'h0_5A5A_0000 + i * 64'h1_0101));
      end
      begin
        for (int i = 0; i < 3; i++) do_rd(AW'(22'h00_0100 + i));
      end
    join
    drain();
    if (kind_q.size() == 6) begin
      check(kind_q[0] == 1'b0, "R8", "write first after read", 64'(kind_q[0]), 64'd0);
      for (int i = 1; i < 6; i++) begin
        check(kind_q[i] != kind_q[i-1], "R8", "alternation", 64'(kind_q[i]), 64'(!kind_q[i-1]));
        check(gap_q[i] == (kind_q[i] ? 4 : 8), "R6", "mixed spacing", 64'(gap_q[i]),
              64'(kind_q[i] ? 4 : 8));
      end
    end else begin
      check(1'b0, "R8", "mixed command count", 64'(kind_q.size()), 64'd6);
    end

    // R10 R2: back-to-back writes then readback with an overwrite
    clear_log();
    for (int i = 0; i < 3; i++) do_wr(AW'(22'h3F_FFF0 + i), 36'(64'hF_0F0F_0F0F ^ (i * 64'h3_3333)));
    do_wr(22'h3F_FFF1, 36'h8_0000_0001);
    for (int i = 0; i < 3; i++) do_rd(AW'(22'h3F_FFF0 + i));
    drain();
    for (int i = 1; i < 4 && i < gap_q.size(); i++)
      check(gap_q[i] == 4, "R2", "write-write spacing", 64'(gap_q[i]), 64'd4);
    check(exp_cyc_q.size() == 0 && exp_data_q.size() == 0, "R7", "responses outstanding",
          64'(exp_data_q.size()), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule